// File: doc/BRIEF.md
# Quad 14-bit DAC Serial Register Core

This block is the digital core of a four-channel, 14-bit digital-to-analog converter as seen from its 3-wire serial port. A host holds the frame-select line low and shifts 24-bit words in, most significant bit first, on rising edges of the serial clock. When frame-select returns high, the most recent 24 bits are decoded into one of three targets: a per-channel input register, a power register, or a control command. The serial lines are sampled by the system clock `clk`, and their edges are detected against that clock.

Each channel is double buffered. Input registers take new codes, and the DAC registers that drive the outputs copy all input registers together when the load pin is low (a pin tied low gives automatic update after each frame) or when a software load command arrives. A clear, from the clear pin or from a command, forces every DAC register to a value set by the coding pin and a control bit. A read request makes the next frame shift the selected register out on `sdo`. Outside a read, `sdo` passes on the shifted bits 24 clocks late, so parts can be chained.

Top module: `qdac_serial_core`

## Requirements
- R1: After reset every DAC code is 0, every power flag is 0 (channel powered down), the clear-select bit is 0 and `sdo` is 0. `coding_offset` follows `bin_offset` one clock late.
- R2: A frame is decoded only when at least 24 serial clock rising edges occurred while `sync_n` was low. With more edges, only the last 24 bits count. With fewer, the frame is ignored.
- R3: Frame layout: bit 23 is the read flag (1 = read), bits 21:19 select the target (000 channel data, 010 power, 011 control), bits 18:16 are an address, and bits 15:0 are data. A data write with address k (0..3) puts bits 15:2 into input register k. Address 100 writes all four. Other targets are ignored.
- R4: DAC registers hold while `ldac_n` is high. While it is low, they copy all input registers on every clock, so a frame is applied automatically.
- R5: Control address 101 copies all input registers to the DAC registers once. Control address 000 does nothing.
- R6: A power write sets `pwr_up[k]` from data bit k, for k = 0..3.
- R7: While `clr_n` is low, every DAC register equals the clear value. The clear value is 0x2000 when `coding_offset` differs from the clear-select bit and 0 otherwise. The input registers keep their contents.
- R8: Control address 100 loads the clear value into every DAC register once.
- R9: Control address 001 sets the clear-select bit from data bit 0.
- R10: A read frame changes no register. During the next frame, `sdo` shows, before each rising serial clock, the 24-bit word made of the read frame's upper 8 bits followed by 16 data bits. The data bits are the input register code shifted left by 2 (channel target), the power flags (power target), or the clear-select bit (control target).
- R11: Outside a readback, the bit on `sdo` before the k-th rising edge of a frame is the bit shifted in 24 edges earlier.
- R12: `dac_code` carries channel k in bits [14k+13:14k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock, data taken on rising edge |
| sync_n | input | 1 | Frame select, active low |
| sdin | input | 1 | Serial data in, MSB first |
| ldac_n | input | 1 | Load pin, low transfers input to DAC registers |
| clr_n | input | 1 | Clear pin, low forces the clear value |
| bin_offset | input | 1 | Coding select: 1 offset binary, 0 twos complement |
| sdo | output | 1 | Serial data out (chain / readback) |
| dac_code | output | 56 | Four 14-bit DAC register codes |
| pwr_up | output | 4 | Per-channel power-up flags |
| coding_offset | output | 1 | Registered coding mode |

## Verification
Channel writes use a distinct code per channel, so a wrong address decode or a swapped channel slice shows up. They are tried with the load pin held high, pulsed, and tied low, which separates buffered from automatic update. The power register is swept over all sixteen patterns. The clear value is tried under all four combinations of coding pin and clear-select bit, which tells midscale from zero-scale. Frames of 23, 24, 30 and 48 bits tell the length rule, the last-24 rule and chain pass-through apart, and a readback of every register checks both the echoed header and the data alignment.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
    localparam int FRAME_W = 24;
    localparam int DATA_W  = 16;
    localparam int SEL_W   = 3;
    localparam int ADDR_W  = 3;

    localparam logic [SEL_W-1:0]  TGT_DATA  = 3'b000;
    localparam logic [SEL_W-1:0]  TGT_POWER = 3'b010;
    localparam logic [SEL_W-1:0]  TGT_CTRL  = 3'b011;

    localparam logic [ADDR_W-1:0] ADDR_BCAST = 3'b100;
    localparam logic [ADDR_W-1:0] CMD_NOP   = 3'b000;
    localparam logic [ADDR_W-1:0] CMD_SET   = 3'b001;
    localparam logic [ADDR_W-1:0] CMD_CLEAR = 3'b100;
    localparam logic [ADDR_W-1:0] CMD_LOAD  = 3'b101;

    typedef struct packed {
        logic              rd;
        logic              rsv;
        logic [SEL_W-1:0]  tgt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;
endpackage

// File: rtl/qdac_shift.sv
module qdac_shift #(
    parameter int FW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk,
    input  logic          sync_n,
    input  logic          sdin,
    input  logic          load_en,
    input  logic [FW-1:0] load_word,
    output logic          frame_valid,
    output logic [FW-1:0] frame_word,
    output logic          sdo,
    output logic          shift_en,
    output logic [$clog2(FW+1)-1:0] bit_cnt
);
    localparam int CW = $clog2(FW + 1);

    typedef struct packed {
        logic          sclk_p;
        logic          sync_p;
        logic [FW-1:0] sr;
        logic [CW-1:0] cnt;
        logic          valid;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.sclk_p = sclk;
        st_d.sync_p = sync_n;
        st_d.valid  = 1'b0;
        shift_en    = sclk && !st_q.sclk_p && !sync_n;
        if (sync_n && !st_q.sync_p) begin
            st_d.valid = (st_q.cnt == CW'(FW));
            st_d.cnt   = '0;
        end else if (shift_en) begin
            st_d.sr = {st_q.sr[FW-2:0], sdin};
            if (st_q.cnt != CW'(FW)) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (load_en) begin
            st_d.sr = load_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sclk_p <= 1'b1;
            st_q.sync_p <= 1'b1;
            st_q.sr     <= '0;
            st_q.cnt    <= '0;
            st_q.valid  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_valid = st_q.valid;
    assign frame_word  = st_q.sr;
    assign sdo         = st_q.sr[FW-1];
    assign bit_cnt     = st_q.cnt;
endmodule

// File: rtl/qdac_regs.sv
module qdac_regs
    import qdac_pkg::*;
#(
    parameter int CH_N   = 4,
    parameter int CODE_W = 14
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_valid,
    input  logic [FRAME_W-1:0]       frame_word,
    input  logic                     ldac_n,
    input  logic                     clr_n,
    input  logic                     bin_offset,
    output logic                     load_en,
    output logic [FRAME_W-1:0]       load_word,
    output logic [CH_N*CODE_W-1:0]   dac_code,
    output logic [CH_N-1:0]          pwr_up,
    output logic                     coding_offset,
    output logic                     clr_sel
);
    localparam int SH = DATA_W - CODE_W;
    localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

    typedef struct packed {
        logic [CH_N-1:0][CODE_W-1:0] inp;
        logic [CH_N-1:0][CODE_W-1:0] dac;
        logic [CH_N-1:0]             pwr;
        logic                        csel;
        logic                        coding;
    } st_t;

    st_t st_d, st_q;
    frame_t             f;
    logic               sw_load;
    logic               sw_clr;
    logic [CODE_W-1:0]  clr_val;
    logic [DATA_W-1:0]  rb_data;

    always_comb begin
        st_d      = st_q;
        st_d.coding = bin_offset;
        f         = frame_t'(frame_word);
        load_en   = 1'b0;
        load_word = '0;
        sw_load   = 1'b0;
        sw_clr    = 1'b0;
        rb_data   = '0;

        case (f.tgt)
            TGT_DATA: begin
                for (int ch = 0; ch < CH_N; ch++) begin
                    if (f.addr == ADDR_W'(ch)) begin
                        rb_data = DATA_W'(st_q.inp[ch]) << SH;
                    end
                end
            end
            TGT_POWER: rb_data = DATA_W'(st_q.pwr);
            TGT_CTRL:  rb_data = DATA_W'(st_q.csel);
            default:   rb_data = '0;
        endcase

        if (frame_valid) begin
            if (f.rd) begin
                load_en   = 1'b1;
                load_word = {frame_word[FRAME_W-1:DATA_W], rb_data};
            end else begin
                case (f.tgt)
                    TGT_DATA: begin
                        for (int ch = 0; ch < CH_N; ch++) begin
                            if (f.addr == ADDR_BCAST || f.addr == ADDR_W'(ch)) begin
                                st_d.inp[ch] = f.data[DATA_W-1 -: CODE_W];
                            end
                        end
                    end
                    TGT_POWER: st_d.pwr = f.data[CH_N-1:0];
                    TGT_CTRL: begin
                        case (f.addr)
                            CMD_SET:   st_d.csel = f.data[0];
                            CMD_CLEAR: sw_clr = 1'b1;
                            CMD_LOAD:  sw_load = 1'b1;
                            default:   ;
                        endcase
                    end
                    default: ;
                endcase
            end
        end

        clr_val = (st_q.coding != st_q.csel) ? MID : '0;
        if (!clr_n || sw_clr) begin
            for (int ch = 0; ch < CH_N; ch++) begin
                st_d.dac[ch] = clr_val;
            end
        end else if (!ldac_n || sw_load) begin
            st_d.dac = st_q.inp;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dac_code      = st_q.dac;
    assign pwr_up        = st_q.pwr;
    assign coding_offset = st_q.coding;
    assign clr_sel       = st_q.csel;
endmodule

// File: rtl/qdac_serial_core.sv
module qdac_serial_core
    import qdac_pkg::*;
#(
    parameter int CH_N   = 4,
    parameter int CODE_W = 14
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sclk,
    input  logic                   sync_n,
    input  logic                   sdin,
    input  logic                   ldac_n,
    input  logic                   clr_n,
    input  logic                   bin_offset,
    output logic                   sdo,
    output logic [CH_N*CODE_W-1:0] dac_code,
    output logic [CH_N-1:0]        pwr_up,
    output logic                   coding_offset
);
    localparam int CW = $clog2(FRAME_W + 1);

    logic               frame_valid;
    logic [FRAME_W-1:0] frame_word;
    logic               load_en;
    logic [FRAME_W-1:0] load_word;
    logic               shift_en;
    logic [CW-1:0]      bit_cnt;
    logic               clr_sel;

    qdac_shift #(.FW(FRAME_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk        (sclk),
        .sync_n      (sync_n),
        .sdin        (sdin),
        .load_en     (load_en),
        .load_word   (load_word),
        .frame_valid (frame_valid),
        .frame_word  (frame_word),
        .sdo         (sdo),
        .shift_en    (shift_en),
        .bit_cnt     (bit_cnt)
    );

    qdac_regs #(.CH_N(CH_N), .CODE_W(CODE_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_valid   (frame_valid),
        .frame_word    (frame_word),
        .ldac_n        (ldac_n),
        .clr_n         (clr_n),
        .bin_offset    (bin_offset),
        .load_en       (load_en),
        .load_word     (load_word),
        .dac_code      (dac_code),
        .pwr_up        (pwr_up),
        .coding_offset (coding_offset),
        .clr_sel       (clr_sel)
    );
endmodule

// File: rtl/qdac_serial_core_chk.sv
module qdac_serial_core_chk #(
    parameter int CH_N   = 4,
    parameter int CODE_W = 14,
    parameter int FW     = 24
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   ldac_n,
    input logic                   clr_n,
    input logic                   sdo,
    input logic [CH_N*CODE_W-1:0] dac_code,
    input logic [CH_N-1:0]        pwr_up,
    input logic                   coding_offset,
    input logic                   frame_valid,
    input logic                   shift_en,
    input logic                   load_en,
    input logic [$clog2(FW+1)-1:0] bit_cnt,
    input logic                   clr_sel
);
    logic [CODE_W-1:0] clr_exp, clr_exp_q;

    assign clr_exp = (coding_offset != clr_sel) ? CODE_W'(1 << (CODE_W - 1)) : '0;

    always_ff @(posedge clk) begin
        clr_exp_q <= clr_exp;
    end

    // R2: a decoded frame always followed a full 24-edge count
    p_full_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> ($past(bit_cnt) == ($clog2(FW+1))'(FW)));

    // R4: with load high, clear high and no frame, DAC registers hold
    p_dac_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ldac_n && clr_n && !frame_valid) |=> $stable(dac_code));

    // R7: clear pin forces the clear value on every channel
    p_clr_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (dac_code == {CH_N{clr_exp_q}}));

    // R6: power flags change only on a decoded frame
    p_pwr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |=> $stable(pwr_up));

    // R10: a read frame leaves the power flags alone
    p_read_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && load_en) |=> $stable(pwr_up));

    // R11: sdo moves only on a shift or a readback load
    p_sdo_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !load_en) |=> $stable(sdo));
endmodule

bind qdac_serial_core qdac_serial_core_chk #(.CH_N(CH_N), .CODE_W(CODE_W), .FW(qdac_pkg::FRAME_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ldac_n        (ldac_n),
    .clr_n         (clr_n),
    .sdo           (sdo),
    .dac_code      (dac_code),
    .pwr_up        (pwr_up),
    .coding_offset (coding_offset),
    .frame_valid   (frame_valid),
    .shift_en      (shift_en),
    .load_en       (load_en),
    .bit_cnt       (bit_cnt),
    .clr_sel       (clr_sel)
);

// File: tb/sim_qdac_serial_core.sv
module sim_qdac_serial_core;
    localparam int CLK_P  = 10;
    localparam int CH_N   = 4;
    localparam int CODE_W = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sync_n = 1'b1, sdin = 1'b0;
    logic ldac_n = 1'b1, clr_n = 1'b1, bin_offset = 1'b1;
    logic sdo;
    logic [CH_N*CODE_W-1:0] dac_code;
    logic [CH_N-1:0] pwr_up;
    logic coding_offset;

    int n_chk = 0, n_fail = 0;
    logic [CODE_W-1:0] m_inp [CH_N];
    logic [CODE_W-1:0] m_dac [CH_N];

    always #(CLK_P/2) clk = ~clk;

    qdac_serial_core u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n), .sdin(sdin),
        .ldac_n(ldac_n), .clr_n(clr_n), .bin_offset(bin_offset), .sdo(sdo),
        .dac_code(dac_code), .pwr_up(pwr_up), .coding_offset(coding_offset)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] mkw(input logic rd, input logic [2:0] tg,
                                        input logic [2:0] ad, input logic [15:0] dt);
        return {rd, 1'b0, tg, ad, dt};
    endfunction

    task automatic xfer(input logic [47:0] bits, input int n, output logic [47:0] seen);
        seen = '0;
        @(negedge clk) sync_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            sdin = bits[i];
            repeat (2) @(negedge clk);
            seen = {seen[46:0], sdo};
            sclk = 1'b1;
            repeat (2) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (2) @(negedge clk);
        sync_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic wr(input logic [23:0] w);
        logic [47:0] s;
        xfer({24'b0, w}, 24, s);
    endtask

    task automatic pulse_ldac();
        @(negedge clk) ldac_n = 1'b0;
        @(negedge clk) ldac_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic chk_dac(input string tag);
        for (int ch = 0; ch < CH_N; ch++) begin
            check(tag, 64'(dac_code[ch*CODE_W +: CODE_W]), 64'(m_dac[ch]));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [47:0] s;
        logic [CODE_W-1:0] cv;
        for (int ch = 0; ch < CH_N; ch++) begin
            m_inp[ch] = '0;
            m_dac[ch] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk_dac("R1 dac reset");
        check("R1 pwr reset", 64'(pwr_up), 64'(0));
        check("R1 sdo reset", 64'(sdo), 64'(0));
        check("R1 coding follows pin", 64'(coding_offset), 64'(1));

        // R3 R12 per-channel writes, held by load pin high (R4)
        for (int ch = 0; ch < CH_N; ch++) begin
            m_inp[ch] = CODE_W'(14'h0123 + ch * 14'h0ABD);
            wr(mkw(1'b0, 3'b000, 3'(ch), {m_inp[ch], 2'b11}));
        end
        chk_dac("R4 held while ldac high");
        pulse_ldac();
        for (int ch = 0; ch < CH_N; ch++) m_dac[ch] = m_inp[ch];
        chk_dac("R3 R12 channel codes after ldac");

        // R3 broadcast address
        wr(mkw(1'b0, 3'b000, 3'b100, {14'h2DB6, 2'b00}));
        for (int ch = 0; ch < CH_N; ch++) m_inp[ch] = 14'h2DB6;
        chk_dac("R4 broadcast held");
        pulse_ldac();
        for (int ch = 0; ch < CH_N; ch++) m_dac[ch] = m_inp[ch];
        chk_dac("R3 broadcast");

        // R4 automatic update with load pin tied low
        @(negedge clk) ldac_n = 1'b0;
        wr(mkw(1'b0, 3'b000, 3'd2, {14'h1F0F, 2'b00}));
        m_inp[2] = 14'h1F0F; m_dac[2] = 14'h1F0F;
        chk_dac("R4 auto update");

        // R2 short frame ignored, long frame uses last 24 bits
        xfer({24'b0, mkw(1'b0, 3'b000, 3'd0, 16'hFFFC)}, 23, s);
        chk_dac("R2 short frame ignored");
        xfer({18'b0, 6'b101101, mkw(1'b0, 3'b000, 3'd1, {14'h0777, 2'b00})}, 30, s);
        m_inp[1] = 14'h0777; m_dac[1] = 14'h0777;
        chk_dac("R2 long frame last 24");
        @(negedge clk) ldac_n = 1'b1;

        // R3 unused target ignored
        wr(mkw(1'b0, 3'b001, 3'd0, 16'hFFFF));
        pulse_ldac();
        chk_dac("R3 unused target ignored");

        // R6 power sweep
        for (int p = 0; p < 16; p++) begin
            wr(mkw(1'b0, 3'b010, 3'd0, 16'(p)));
            check("R6 power flags", 64'(pwr_up), 64'(p));
        end

        // R7 R9 clear pin under all coding / select pairs
        for (int cd = 0; cd < 2; cd++) begin
            for (int cs = 0; cs < 2; cs++) begin
                @(negedge clk) bin_offset = cd[0];
                repeat (2) @(negedge clk);
                check("R1 coding follows pin", 64'(coding_offset), 64'(cd));
                wr(mkw(1'b0, 3'b011, 3'b001, 16'(cs)));
                @(negedge clk) clr_n = 1'b0;
                repeat (2) @(negedge clk);
                cv = (cd != cs) ? 14'h2000 : 14'h0000;
                for (int ch = 0; ch < CH_N; ch++) m_dac[ch] = cv;
                chk_dac("R7 R9 clear pin value");
                clr_n = 1'b1;
                repeat (2) @(negedge clk);
                chk_dac("R7 held after clear");
                pulse_ldac();
                for (int ch = 0; ch < CH_N; ch++) m_dac[ch] = m_inp[ch];
                chk_dac("R7 input regs kept");
            end
        end

        // R8 software clear (coding 1, select 1 -> zero)
        wr(mkw(1'b0, 3'b011, 3'b100, 16'h0));
        for (int ch = 0; ch < CH_N; ch++) m_dac[ch] = '0;
        chk_dac("R8 software clear");
        // R5 NOP then software load
        wr(mkw(1'b0, 3'b011, 3'b000, 16'hFFFF));
        chk_dac("R5 nop no effect");
        wr(mkw(1'b0, 3'b011, 3'b101, 16'h0));
        for (int ch = 0; ch < CH_N; ch++) m_dac[ch] = m_inp[ch];
        chk_dac("R5 software load");

        // R10 readback of each channel, power and control
        for (int ch = 0; ch < CH_N; ch++) begin
            wr(mkw(1'b1, 3'b000, 3'(ch), 16'h0));
            xfer({24'b0, mkw(1'b0, 3'b011, 3'b000, 16'h0)}, 24, s);
            check("R10 channel readback", 64'(s[23:0]),
                  64'({1'b1, 1'b0, 3'b000, 3'(ch), m_inp[ch], 2'b00}));
        end
        wr(mkw(1'b1, 3'b010, 3'd0, 16'h0));
        xfer({24'b0, mkw(1'b0, 3'b011, 3'b000, 16'h0)}, 24, s);
        check("R10 power readback", 64'(s[23:0]), 64'(24'h900000 | 24'h00000F));
        check("R10 read keeps power", 64'(pwr_up), 64'(15));
        wr(mkw(1'b1, 3'b011, 3'd0, 16'h0));
        xfer({24'b0, mkw(1'b0, 3'b011, 3'b000, 16'h0)}, 24, s);
        check("R10 control readback", 64'(s[23:0]), 64'(24'h980001));
        chk_dac("R10 read keeps dac");

        // R11 chain pass-through
        xfer({24'hA5C396, mkw(1'b0, 3'b010, 3'd0, 16'h0006)}, 48, s);
        check("R11 chained word out", 64'(s[23:0]), 64'(24'hA5C396));
        check("R11 chained last word decoded", 64'(pwr_up), 64'(6));

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule